// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block is the address-phase front end of an I2C slave. It watches already-synchronized copies of the serial clock and serial data lines, and it recognizes a start condition. It then collects the following eight bits, most significant first, into a receive register. When the byte is complete, it compares the upper seven bits with a programmable own address.

When the address matches, the block raises its addressed flag and takes the transfer direction from the read/write bit. It also asserts an open-drain pull-down enable, which drives the acknowledge low for the ninth clock. When the address does not match, the block leaves the bus alone until the next start or stop. The data phase that follows the address, and any clock stretching, belong to other logic.

Top module: `i2c_addr_match`

## Requirements
- R1: After a synchronous active-low reset, `addressed`, `dir_tx` and `sda_pull` are 0.
- R2: A start condition is SDA falling while SCL is high. It begins address reception when `dir_tx` is 0. Bits are sampled on SCL rising edges and shifted into `rx_byte` most significant bit first, so the first bit on the bus ends in `rx_byte[7]`.
- R3: After the eighth bit, `rx_byte[7:1]` is compared with `own_addr[6:0]`. On a match, `sda_pull` is 1 from the eighth SCL falling edge to the ninth SCL falling edge, which pulls the acknowledge bit low.
- R4: On a match, `addressed` becomes 1 and `dir_tx` becomes `rx_byte[0]` (1 = master reads, slave transmits). Both stay set until a stop or a restart.
- R5: On a mismatch, `sda_pull` stays 0, `addressed` stays 0 and `dir_tx` stays 0. Later SCL clocks are ignored until the next start or stop, so `rx_byte` keeps the mismatching byte.
- R6: A stop condition is SDA rising while SCL is high. It clears `addressed`, `dir_tx` and `sda_pull` in any state.
- R7: A start condition while `dir_tx` is 1 is ignored. `addressed`, `dir_tx` and `rx_byte` keep their values through the following clocks.
- R8: A repeated start while addressed with `dir_tx` = 0 clears `addressed` and restarts reception and comparison of a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line |
| own_addr | input | 7 | Programmable own slave address |
| addressed | output | 1 | Set when the received address matched |
| dir_tx | output | 1 | Transfer direction taken from the read/write bit |
| sda_pull | output | 1 | Enable for the SDA open-drain pull-down |
| rx_byte | output | 8 | Receive shift register |

## Verification
The bench sends random address bytes against a random own address. It also targets these cases:
- A byte that differs from the own address in a single bit. A comparator that is loose or off by one would acknowledge it.
- Extra clocks after a mismatch. A design that keeps shifting would corrupt `rx_byte` or pull SDA low.
- A repeated start while the direction is transmit. A design that accepts it would drop `addressed` or overwrite `rx_byte`.
- A repeated start while addressed for a write. A design that misses it would keep a stale `addressed`.

The bench samples the line during the ninth clock and again after its falling edge. An early or late release of the pull-down therefore shows up as a wrong acknowledge or a stuck-low SDA.

// File: rtl/i2c_am_pkg.sv
// Shared types for the I2C slave address matcher.
package i2c_am_pkg;
    // Address-phase controller states.
    typedef enum logic [1:0] {
        AM_IDLE = 2'd0,  // waiting for a start; also the state after a mismatch
        AM_RECV = 2'd1,  // shifting in the address byte
        AM_ACK  = 2'd2,  // driving the acknowledge bit low
        AM_HOLD = 2'd3   // addressed; data phase handled elsewhere
    } am_state_t;
endpackage

// File: rtl/i2c_am_edge.sv
// Bus event detector. It compares the current synchronized SCL/SDA levels
// with the values registered one cycle earlier and reports SCL edges and
// start/stop conditions as single-cycle pulses.
// Assumes scl_i/sda_i are already synchronized to clk.
module i2c_am_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q;
    logic sda_q;

    // Hold the previous line levels; an idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode edges and the two bus conditions.
    always_comb begin
        scl_rise = scl_i & ~scl_q;
        scl_fall = ~scl_i & scl_q;
        start_ev = scl_i & scl_q & sda_q & ~sda_i;
        stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/i2c_am_shift.sv
// Receive shift register with bit counter. On each sample pulse it shifts
// bit_in in at the LSB (so the first bit ends at the MSB) and counts the bits.
// Assumes sample is never asserted once the count has reached BYTE_W.
module i2c_am_shift #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] data,
    output logic              full
);
    logic [CNT_W-1:0] count;

    // Shift the data and count the bits; clear only restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (sample) begin
            data  <= {data[BYTE_W-2:0], bit_in};
            count <= count + CNT_W'(1);
        end
    end

    // Flag a complete byte.
    always_comb full = (count == CNT_W'(BYTE_W));

    // The counter never passes one byte.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(BYTE_W));
endmodule

// File: rtl/i2c_addr_match.sv
// I2C slave address matcher (top). It detects a start, collects the address
// byte, compares its upper bits with own_addr, drives the acknowledge, and
// sets the addressed and direction flags.
// Assumes synchronized inputs; the data phase is handled by other logic.
module i2c_addr_match #(
    parameter int ADDR_W = 7,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              addressed,
    output logic              dir_tx,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] rx_byte
);
    import i2c_am_pkg::*;

    am_state_t state;
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic byte_full, restart, shift_clr, shift_smp, addr_hit;

    i2c_am_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    // A start is accepted only in slave receive direction.
    always_comb begin
        restart   = start_ev & ~dir_tx;
        shift_clr = stop_ev | restart;
        shift_smp = scl_rise & (state == AM_RECV) & ~byte_full;
        addr_hit  = (rx_byte[BYTE_W-1:1] == own_addr);
    end

    i2c_am_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (shift_clr),
        .sample (shift_smp),
        .bit_in (sda_i),
        .data   (rx_byte),
        .full   (byte_full)
    );

    // Address-phase sequencing and the flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= AM_IDLE;
            addressed <= 1'b0;
            dir_tx    <= 1'b0;
            sda_pull  <= 1'b0;
        end else if (stop_ev) begin
            state     <= AM_IDLE;
            addressed <= 1'b0;
            dir_tx    <= 1'b0;
            sda_pull  <= 1'b0;
        end else if (restart) begin
            state     <= AM_RECV;
            addressed <= 1'b0;
            sda_pull  <= 1'b0;
        end else begin
            case (state)
                AM_RECV: if (scl_fall && byte_full) begin
                    if (addr_hit) begin
                        state     <= AM_ACK;
                        addressed <= 1'b1;
                        dir_tx    <= rx_byte[0];
                        sda_pull  <= 1'b1;
                    end else begin
                        state <= AM_IDLE;
                    end
                end
                AM_ACK: if (scl_fall) begin
                    state    <= AM_HOLD;
                    sda_pull <= 1'b0;
                end
                default: state <= state;
            endcase
        end
    end

    // Pull-down only while addressed.
    p_pull_needs_aas_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> addressed);
    // Pull-down released after the falling edge that ends the acknowledge bit.
    p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == AM_ACK && scl_fall) |=> !sda_pull);
    // Direction can be set only together with a match.
    p_trx_needs_aas_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dir_tx |-> addressed);
    // A stop clears every flag.
    p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!addressed && !dir_tx && !sda_pull));
    // A start while transmitting leaves the flags alone.
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && dir_tx && !stop_ev) |=> (addressed && dir_tx));
endmodule

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic [6:0] own = 7'h5A;
    logic aas, trx, pull;
    logic [7:0] rxb;
    wire sda_line = sda_drv & ~pull;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    i2c_addr_match u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .own_addr(own), .addressed(aas), .dir_tx(trx),
        .sda_pull(pull), .rx_byte(rxb)
    );

    function automatic logic exp_hit(input logic [7:0] b, input logic [6:0] a);
        return b[7:1] == a;
    endfunction

    function automatic logic exp_dir(input logic [7:0] b, input logic [6:0] a);
        return exp_hit(b, a) ? b[0] : 1'b0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wq(Q);
        scl = 1'b1;     wq(Q);
        sda_drv = 1'b0; wq(Q);
        scl = 1'b0;     wq(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wq(Q);
        scl = 1'b1;     wq(Q);
        sda_drv = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b; wq(Q);
        scl = 1'b1;  wq(2 * Q);
        scl = 1'b0;  wq(Q);
    endtask

    // Start, then send an address byte and clock the acknowledge, checking as it goes.
    task automatic addr_phase(input logic [7:0] b, input string tag);
        logic hit;
        logic ack;
        hit = exp_hit(b, own);
        bus_start();
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        check({tag, " R3 pull after 8th bit"}, pull, hit);
        check({tag, " R5 aas before ack"}, aas, hit);
        sda_drv = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        ack = sda_line;
        check({tag, " R3 ack level"}, ack, !hit);
        wq(Q);
        scl = 1'b0; wq(Q);
        check({tag, " R3 release after 9th"}, pull, 1'b0);
        check({tag, " R2 rx_byte"}, rxb, b);
        check({tag, " R4 aas"}, aas, hit);
        check({tag, " R4 trx"}, trx, exp_dir(b, own));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] b;
        void'($urandom(32'd1234));
        wq(5);
        check("R1 aas reset", aas, 1'b0);
        check("R1 trx reset", trx, 1'b0);
        check("R1 pull reset", pull, 1'b0);
        rst_n = 1'b1;
        wq(3);

        // Directed: write match, then a repeated start (R8) with a read match.
        addr_phase({own, 1'b0}, "wr");
        bus_start();
        check("R8 aas cleared by restart", aas, 1'b0);
        for (int i = 7; i >= 0; i--) send_bit(i == 0 ? 1'b1 : own[i-1]);
        check("R8 pull after restart byte", pull, 1'b1);
        sda_drv = 1'b1; wq(Q); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q);
        check("R8 aas after restart", aas, 1'b1);
        check("R4 trx read", trx, 1'b1);

        // R7: a start while transmitting is ignored.
        bus_start();
        for (int i = 0; i < 9; i++) send_bit(1'b0);
        check("R7 aas kept", aas, 1'b1);
        check("R7 trx kept", trx, 1'b1);
        check("R7 rx kept", rxb, {own, 1'b1});
        check("R7 no pull", pull, 1'b0);
        bus_stop();
        check("R6 aas cleared", aas, 1'b0);
        check("R6 trx cleared", trx, 1'b0);

        // R5: single-bit mismatch, then extra clocks are ignored.
        b = {own ^ 7'h01, 1'b1};
        addr_phase(b, "miss");
        for (int i = 0; i < 10; i++) begin
            send_bit(1'b0);
            check("R5 pull idle", pull, 1'b0);
        end
        check("R5 rx kept", rxb, b);
        check("R5 aas idle", aas, 1'b0);
        bus_stop();

        // Random mix.
        for (int t = 0; t < 40; t++) begin
            own = 7'($urandom);
            if ($urandom % 2 == 0) b = {own, 1'($urandom)};
            else b = 8'($urandom);
            addr_phase(b, "rand");
            bus_stop();
            check("R6 rand aas", aas, 1'b0);
            check("R6 rand trx", trx, 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule